// File: doc/BRIEF.md
# Circuit-Switched Mesh Router Node

One node of a two-dimensional on-chip mesh in which a connection is set up before any payload moves. A source raises a request that carries a destination coordinate. Each node decodes the coordinate into one of five directions (north, east, south, west, local), arbitrates for that output, reserves a crossbar path and forwards the request to the next node. Once the far end accepts, a grant travels back over the reserved path. Only then may words stream through. A last-word marker that rides with the data frees the path in every node it passes.

The node holds no payload storage. Words cross the crossbar combinationally. The only state is the per-input connection state, the latched destination, and the per-output owner and round-robin pointer. Routing is fixed and dimension ordered, so one source and destination pair always uses the same path. A parameter caps how many circuits the node may hold at the same time, which is part of keeping the mesh free of deadlock.

Top module: `cs_mesh_router`

## Requirements
- R1: After reset, every req_out, grant_out, valid_out and last_out bit is low.
- R2: Port index encoding is 0 north, 1 east, 2 south, 3 west, 4 local. A destination address is {x, y}, with x in the upper X_W bits. An x greater than the node's own x selects east and a smaller x selects west. When x matches, a larger y selects north and a smaller y selects south. When both match, local is selected.
- R3: A request that wins an output drives req_out on that output from the cycle after the win. addr_out carries the latched destination, and both stay steady until release.
- R4: grant_out of the owning input follows the downstream grant_in while the circuit waits for acceptance. After one grant has been seen, grant_out stays high until release, even if grant_in falls.
- R5: valid_in, last_in and data_in reach the owned output in the same cycle, but only while the input's grant_out is high. Words offered before the grant do not appear on valid_out.
- R6: A word accepted with last_in set frees the circuit. From the next cycle req_out on that output is low, and a waiting request may win the output in that cycle.
- R7: When several idle inputs request one free output, the winner is the first requester at or after the output's pointer, taken in cyclic index order. The pointer then moves to the winner's index plus one.
- R8: A losing request forwards nothing. Its output req_out stays with the winner, its grant_out stays low, and it wins later without being raised again.
- R9: At most MAX_CONN circuits are held at once. When more free outputs have requesters than the remaining allowance, the lower-numbered outputs are served first and the rest wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 5 | Circuit request per input direction |
| addr_in | input | 5*(X_W+Y_W) | Destination {x,y} per input, sampled on winning |
| valid_in | input | 5 | Word present per input |
| last_in | input | 5 | Final word of the transfer per input |
| data_in | input | 5*DATA_W | Payload per input |
| grant_out | output | 5 | Grant returned toward each source |
| req_out | output | 5 | Forwarded request per output direction |
| addr_out | output | 5*(X_W+Y_W) | Forwarded destination per output |
| grant_in | input | 5 | Grant from the next hop per output |
| valid_out | output | 5 | Word present per output |
| last_out | output | 5 | Final-word marker per output |
| data_out | output | 5*DATA_W | Payload per output |

## Verification
The assertions assume the handshake discipline of a source: req_in stays high from its raising until the cycle that carries the last word, and the next hop holds grant_in for as long as the circuit is in use. The bench keeps to this. It raises a request at a falling edge and drops it only after the release edge. It drops grant_in as the downstream side would, except in the one case that tests the grant latch, which does not depend on grant_in. Under these conditions a released output can be reclaimed only by a request that is still pending.

// File: rtl/cs_router_pkg.sv
package cs_router_pkg;
   localparam int NPORT = 5;
   localparam int PW    = 3;

   typedef enum logic [PW-1:0] {
      P_NORTH = 3'd0,
      P_EAST  = 3'd1,
      P_SOUTH = 3'd2,
      P_WEST  = 3'd3,
      P_LOCAL = 3'd4
   } dir_e;

   typedef enum logic [1:0] {
      CS_IDLE   = 2'd0,
      CS_SETUP  = 2'd1,
      CS_STREAM = 2'd2
   } conn_st_e;
endpackage

// File: rtl/cs_xy_decoder.sv
module cs_xy_decoder
   import cs_router_pkg::*;
#(
   parameter int X_W  = 2,
   parameter int Y_W  = 2,
   parameter int MY_X = 1,
   parameter int MY_Y = 1
) (
   input  logic [X_W+Y_W-1:0] addr,
   output logic [NPORT-1:0]   dir_oh
);
   localparam int AW = X_W + Y_W;
   localparam logic [X_W-1:0] HX = X_W'(MY_X);
   localparam logic [Y_W-1:0] HY = Y_W'(MY_Y);

   logic [X_W-1:0] dx;
   logic [Y_W-1:0] dy;
   dir_e           dir;

   assign dx = addr[AW-1 -: X_W];
   assign dy = addr[Y_W-1:0];

   // x dimension is resolved before y
   always_comb begin
      if (dx > HX)      dir = P_EAST;
      else if (dx < HX) dir = P_WEST;
      else if (dy > HY) dir = P_NORTH;
      else if (dy < HY) dir = P_SOUTH;
      else              dir = P_LOCAL;
   end

   always_comb begin
      dir_oh = '0;
      dir_oh[dir] = 1'b1;
   end
endmodule

// File: rtl/cs_rr_arbiter.sv
module cs_rr_arbiter #(
   parameter int N  = 5,
   parameter int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  req,
   input  logic          allow,
   input  logic          release_i,
   output logic          cand,
   output logic [N-1:0]  gnt,
   output logic          owned,
   output logic [IW-1:0] owner
);
   logic [IW-1:0] ptr;
   logic [N-1:0]  pick;
   logic [IW-1:0] pick_idx;

   assign cand = !owned && (|req);

   // first requester at or after the pointer, cyclic order
   always_comb begin
      logic found;
      found    = 1'b0;
      pick     = '0;
      pick_idx = '0;
      for (int k = 0; k < N; k++) begin
         int idx;
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (!found && req[idx]) begin
            found         = 1'b1;
            pick[idx]     = 1'b1;
            pick_idx      = IW'(idx);
         end
      end
   end

   assign gnt = (cand && allow) ? pick : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         owned <= 1'b0;
         owner <= '0;
         ptr   <= '0;
      end else if (|gnt) begin
         owned <= 1'b1;
         owner <= pick_idx;
         ptr   <= (int'(pick_idx) == N - 1) ? '0 : pick_idx + 1'b1;
      end else if (release_i) begin
         owned <= 1'b0;
      end
   end

   // R7: never more than one input granted in a cycle
   a_r7_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   // R3: an owned output keeps its owner until released
   a_r3_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
      (owned && !release_i) |=> (owned && $stable(owner)));
endmodule

// File: rtl/cs_port_ctrl.sv
module cs_port_ctrl
   import cs_router_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          won,
   input  logic [PW-1:0] won_dir,
   input  logic [AW-1:0] addr_in,
   input  logic          grant_dn,
   input  logic          valid_in,
   input  logic          last_in,
   output logic          grant_up,
   output logic          fire_last,
   output logic          busy,
   output logic [PW-1:0] sel,
   output logic [AW-1:0] addr_q
);
   conn_st_e st;

   assign busy      = (st != CS_IDLE);
   assign grant_up  = (st == CS_STREAM) || ((st == CS_SETUP) && grant_dn);
   assign fire_last = grant_up && valid_in && last_in;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= CS_IDLE;
         sel    <= '0;
         addr_q <= '0;
      end else begin
         case (st)
            CS_IDLE: begin
               if (won) begin
                  st     <= CS_SETUP;
                  sel    <= won_dir;
                  addr_q <= addr_in;
               end
            end
            CS_SETUP: begin
               if (fire_last)     st <= CS_IDLE;
               else if (grant_dn) st <= CS_STREAM;
            end
            CS_STREAM: begin
               if (fire_last) st <= CS_IDLE;
            end
            default: st <= CS_IDLE;
         endcase
      end
   end

   // R6: last accepted word frees the input
   a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
      fire_last |=> !busy);

   // R4: once granted, the grant stays until release
   a_r4_grant_latched: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_up && !fire_last) |=> grant_up);
endmodule

// File: rtl/cs_crossbar.sv
module cs_crossbar #(
   parameter int NP = 5,
   parameter int PW = 3,
   parameter int AW = 4,
   parameter int DW = 8
) (
   input  logic [NP-1:0] owned,
   input  logic [PW-1:0] owner    [NP],
   input  logic [AW-1:0] addr_q   [NP],
   input  logic [DW-1:0] data_in  [NP],
   input  logic [NP-1:0] valid_in,
   input  logic [NP-1:0] last_in,
   input  logic [NP-1:0] grant_up,
   input  logic [NP-1:0] busy,
   input  logic [PW-1:0] sel      [NP],
   input  logic [NP-1:0] grant_in,
   output logic [NP-1:0] req_out,
   output logic [AW-1:0] addr_out [NP],
   output logic [DW-1:0] data_out [NP],
   output logic [NP-1:0] valid_out,
   output logic [NP-1:0] last_out,
   output logic [NP-1:0] grant_dn
);
   for (genvar o = 0; o < NP; o++) begin : g_out
      logic pass;
      assign pass        = owned[o] && grant_up[owner[o]];
      assign req_out[o]  = owned[o];
      assign addr_out[o] = owned[o] ? addr_q[owner[o]] : '0;
      assign data_out[o] = pass ? data_in[owner[o]] : '0;
      assign valid_out[o] = pass && valid_in[owner[o]];
      assign last_out[o]  = pass && valid_in[owner[o]] && last_in[owner[o]];
   end

   for (genvar i = 0; i < NP; i++) begin : g_in
      assign grant_dn[i] = busy[i] && grant_in[sel[i]];
   end
endmodule

// File: rtl/cs_mesh_router.sv
module cs_mesh_router
   import cs_router_pkg::*;
#(
   parameter int X_W      = 2,
   parameter int Y_W      = 2,
   parameter int DATA_W   = 8,
   parameter int MY_X     = 1,
   parameter int MY_Y     = 1,
   parameter int MAX_CONN = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NPORT-1:0]              req_in,
   input  logic [NPORT*(X_W+Y_W)-1:0]    addr_in,
   input  logic [NPORT-1:0]              valid_in,
   input  logic [NPORT-1:0]              last_in,
   input  logic [NPORT*DATA_W-1:0]       data_in,
   output logic [NPORT-1:0]              grant_out,
   output logic [NPORT-1:0]              req_out,
   output logic [NPORT*(X_W+Y_W)-1:0]    addr_out,
   input  logic [NPORT-1:0]              grant_in,
   output logic [NPORT-1:0]              valid_out,
   output logic [NPORT-1:0]              last_out,
   output logic [NPORT*DATA_W-1:0]       data_out
);
   localparam int AW = X_W + Y_W;
   localparam int NP = NPORT;

   if (MAX_CONN < 1 || MAX_CONN > NP) begin : g_bad_conn
      $error("MAX_CONN must lie between 1 and the port count");
   end
   if (X_W < 1 || Y_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("coordinate and data widths must be positive");
   end
   if (MY_X >= (1 << X_W) || MY_Y >= (1 << Y_W)) begin : g_bad_pos
      $error("node position does not fit the coordinate width");
   end

   logic [NP-1:0]     dec_oh [NP];   // [input][output]
   logic [NP-1:0]     want   [NP];   // [output][input]
   logic [NP-1:0]     gnt    [NP];   // [output][input]
   logic [NP-1:0]     cand, allow, owned, rel;
   logic [PW-1:0]     owner  [NP];
   logic [NP-1:0]     won, grant_up, fire_last, busy, grant_dn;
   logic [PW-1:0]     won_dir [NP];
   logic [PW-1:0]     sel     [NP];
   logic [AW-1:0]     addr_i  [NP];
   logic [AW-1:0]     addr_q  [NP];
   logic [AW-1:0]     addr_o  [NP];
   logic [DATA_W-1:0] data_i  [NP];
   logic [DATA_W-1:0] data_o  [NP];

   for (genvar p = 0; p < NP; p++) begin : g_unpack
      assign addr_i[p] = addr_in[p*AW +: AW];
      assign data_i[p] = data_in[p*DATA_W +: DATA_W];
      assign addr_out[p*AW +: AW]         = addr_o[p];
      assign data_out[p*DATA_W +: DATA_W] = data_o[p];
   end

   for (genvar i = 0; i < NP; i++) begin : g_dec
      cs_xy_decoder #(
         .X_W (X_W),
         .Y_W (Y_W),
         .MY_X(MY_X),
         .MY_Y(MY_Y)
      ) u_dec (
         .addr  (addr_i[i]),
         .dir_oh(dec_oh[i])
      );
   end

   always_comb begin
      for (int o = 0; o < NP; o++)
         for (int i = 0; i < NP; i++)
            want[o][i] = req_in[i] && !busy[i] && dec_oh[i][o];
   end

   // connection cap: lower output indices take the remaining allowance
   always_comb begin
      int act;
      int pre;
      act = $countones(owned);
      pre = 0;
      for (int o = 0; o < NP; o++) begin
         allow[o] = (act + pre) < MAX_CONN;
         if (cand[o]) pre = pre + 1;
      end
   end

   for (genvar o = 0; o < NP; o++) begin : g_arb
      assign rel[o] = owned[o] && fire_last[owner[o]];
      cs_rr_arbiter #(
         .N (NP),
         .IW(PW)
      ) u_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .req      (want[o]),
         .allow    (allow[o]),
         .release_i(rel[o]),
         .cand     (cand[o]),
         .gnt      (gnt[o]),
         .owned    (owned[o]),
         .owner    (owner[o])
      );
   end

   always_comb begin
      for (int i = 0; i < NP; i++) begin
         won[i]     = 1'b0;
         won_dir[i] = '0;
         for (int o = 0; o < NP; o++) begin
            if (gnt[o][i]) begin
               won[i]     = 1'b1;
               won_dir[i] = PW'(o);
            end
         end
      end
   end

   for (genvar i = 0; i < NP; i++) begin : g_ctrl
      cs_port_ctrl #(
         .AW(AW)
      ) u_ctrl (
         .clk      (clk),
         .rst_n    (rst_n),
         .won      (won[i]),
         .won_dir  (won_dir[i]),
         .addr_in  (addr_i[i]),
         .grant_dn (grant_dn[i]),
         .valid_in (valid_in[i]),
         .last_in  (last_in[i]),
         .grant_up (grant_up[i]),
         .fire_last(fire_last[i]),
         .busy     (busy[i]),
         .sel      (sel[i]),
         .addr_q   (addr_q[i])
      );
   end

   cs_crossbar #(
      .NP(NP),
      .PW(PW),
      .AW(AW),
      .DW(DATA_W)
   ) u_xbar (
      .owned    (owned),
      .owner    (owner),
      .addr_q   (addr_q),
      .data_in  (data_i),
      .valid_in (valid_in),
      .last_in  (last_in),
      .grant_up (grant_up),
      .busy     (busy),
      .sel      (sel),
      .grant_in (grant_in),
      .req_out  (req_out),
      .addr_out (addr_o),
      .data_out (data_o),
      .valid_out(valid_out),
      .last_out (last_out),
      .grant_dn (grant_dn)
   );

   assign grant_out = grant_up;

   // R9: never more circuits than the cap
   a_r9_conn_cap: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(req_out) <= MAX_CONN);

   // R5: a word only appears on an output that carries a circuit
   a_r5_data_on_circuit: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_out & ~req_out) == '0);

   // R3: a forwarded request keeps its address while it stays up
   a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (req_out == $past(req_out)) |-> (addr_out == $past(addr_out)) || $past(!rst_n));
endmodule

// File: tb/cs_mesh_router_test.sv
module cs_mesh_router_test;
   localparam int XW = 2, YW = 2, DW = 8, AW = 4;
   localparam int HX = 1, HY = 1, CAP = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0]      req_in = '0, valid_in = '0, last_in = '0, grant_in = '0;
   logic [5*AW-1:0] addr_in = '0;
   logic [5*DW-1:0] data_in = '0;
   logic [4:0]      grant_out, req_out, valid_out, last_out;
   logic [5*AW-1:0] addr_out;
   logic [5*DW-1:0] data_out;

   int checks = 0;
   int errors = 0;
   int ptr [5] = '{0, 0, 0, 0, 0};

   always #10 clk = ~clk;

   cs_mesh_router #(
      .X_W(XW), .Y_W(YW), .DATA_W(DW), .MY_X(HX), .MY_Y(HY), .MAX_CONN(CAP)
   ) uut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr_in(addr_in),
      .valid_in(valid_in), .last_in(last_in), .data_in(data_in),
      .grant_out(grant_out), .req_out(req_out), .addr_out(addr_out),
      .grant_in(grant_in), .valid_out(valid_out), .last_out(last_out),
      .data_out(data_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int exp_dir(input int x, input int y);
      if (x > HX) return 1;
      if (x < HX) return 3;
      if (y > HY) return 0;
      if (y < HY) return 2;
      return 4;
   endfunction

   function automatic int rr_pick(input int p, input logic [4:0] m);
      for (int k = 0; k < 5; k++) begin
         if (m[(p + k) % 5]) return (p + k) % 5;
      end
      return -1;
   endfunction

   task automatic idle_all();
      req_in = '0; valid_in = '0; last_in = '0; grant_in = '0;
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: quiet outputs after reset
      chk("R1 req_out", int'(req_out), 0);
      chk("R1 grant_out", int'(grant_out), 0);
      chk("R1 valid_out", int'(valid_out), 0);
      chk("R1 last_out", int'(last_out), 0);

      // R2/R3/R4/R5/R6: every input to every destination
      for (int i = 0; i < 5; i++) begin
         for (int d = 0; d < 16; d++) begin
            int e;
            int dat;
            e = exp_dir(d >> 2, d & 3);
            dat = (i * 16 + d) & 8'hff;
            @(negedge clk);
            req_in[i] = 1'b1;
            addr_in[i*AW +: AW] = AW'(d);
            @(posedge clk); #1;
            chk("R2 decoded output", int'(req_out), 1 << e);
            chk("R3 forwarded addr", int'(addr_out[e*AW +: AW]), d);
            @(negedge clk);
            addr_in[i*AW +: AW] = '0;
            valid_in[i] = 1'b1;
            data_in[i*DW +: DW] = DW'(dat);
            #1;
            chk("R5 no word before grant", int'(valid_out), 0);
            chk("R4 no grant yet", int'(grant_out), 0);
            grant_in[e] = 1'b1;
            last_in[i] = 1'b1;
            #1;
            chk("R4 grant back", int'(grant_out), 1 << i);
            chk("R5 word through", int'(valid_out & last_out), 1 << e);
            chk("R5 data through", int'(data_out[e*DW +: DW]), dat);
            chk("R3 addr held", int'(addr_out[e*AW +: AW]), d);
            @(posedge clk); #1;
            chk("R6 released", int'(req_out), 0);
            ptr[e] = (i + 1) % 5;
            @(negedge clk);
            idle_all();
         end
      end

      // R7/R8/R4: north and south inputs contend for east, two rounds
      for (int round = 0; round < 2; round++) begin
         int w;
         int l;
         w = rr_pick(ptr[1], 5'b00101);
         l = (w == 0) ? 2 : 0;
         @(negedge clk);
         req_in[0] = 1'b1; addr_in[0*AW +: AW] = 4'b1101;
         req_in[2] = 1'b1; addr_in[2*AW +: AW] = 4'b1100;
         @(posedge clk); #1;
         chk("R7 one circuit east", int'(req_out), 5'b00010);
         chk("R7 winner addr", int'(addr_out[1*AW +: AW]), (w == 0) ? 13 : 12);
         @(negedge clk);
         grant_in[1] = 1'b1;
         #1;
         chk("R8 grant only to winner", int'(grant_out), 1 << w);
         @(negedge clk);
         grant_in[1] = 1'b0;
         #1;
         chk("R4 grant latched", int'(grant_out), 1 << w);
         valid_in[w] = 1'b1; last_in[w] = 1'b1; data_in[w*DW +: DW] = 8'h5a;
         #1;
         chk("R5 winner data", int'(data_out[1*DW +: DW]), 8'h5a);
         @(posedge clk); #1;
         chk("R6 east free", int'(req_out), 0);
         ptr[1] = (w + 1) % 5;
         @(negedge clk);
         req_in[w] = 1'b0; valid_in[w] = 1'b0; last_in[w] = 1'b0;
         @(posedge clk); #1;
         chk("R8 pending loser wins", int'(req_out), 5'b00010);
         chk("R8 loser addr", int'(addr_out[1*AW +: AW]), (l == 0) ? 13 : 12);
         @(negedge clk);
         grant_in[1] = 1'b1; valid_in[l] = 1'b1; last_in[l] = 1'b1;
         @(posedge clk); #1;
         chk("R6 loser done", int'(req_out), 0);
         ptr[1] = (l + 1) % 5;
         @(negedge clk);
         idle_all();
      end

      // R9: three requests, cap of two
      @(negedge clk);
      req_in[0] = 1'b1; addr_in[0*AW +: AW] = 4'b0001;   // west
      req_in[1] = 1'b1; addr_in[1*AW +: AW] = 4'b0110;   // north
      req_in[2] = 1'b1; addr_in[2*AW +: AW] = 4'b0101;   // local
      @(posedge clk); #1;
      chk("R9 cap, lower outputs first", int'(req_out), 5'b01001);
      @(negedge clk);
      grant_in[0] = 1'b1; valid_in[1] = 1'b1; last_in[1] = 1'b1;
      #1;
      chk("R8 capped request waits", int'(grant_out), 5'b00010);
      @(posedge clk); #1;
      chk("R6 north free", int'(req_out), 5'b01000);
      @(negedge clk);
      req_in[1] = 1'b0; valid_in[1] = 1'b0; last_in[1] = 1'b0; grant_in[0] = 1'b0;
      @(posedge clk); #1;
      chk("R9 waiting request admitted", int'(req_out), 5'b11000);
      @(negedge clk);
      grant_in[3] = 1'b1; grant_in[4] = 1'b1;
      valid_in[0] = 1'b1; last_in[0] = 1'b1;
      valid_in[2] = 1'b1; last_in[2] = 1'b1;
      @(posedge clk); #1;
      chk("R6 all free", int'(req_out), 0);
      @(negedge clk);
      idle_all();
      @(posedge clk); #1;
      chk("R1 idle again", int'(grant_out | valid_out), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule